// File: doc/BRIEF.md
# Sum-of-Products Port Macrocell Array

This block is a small general-purpose programmable logic function tied to an 8-bit I/O port. A programmable AND array looks at a 37-signal bus. That bus is made of 29 external signals plus the eight port pin values read back. Each of the eight port cells ORs its own four product terms and can invert the result. Each cell then acts either as a dedicated output or as a dedicated input. A ninth kind of term, one shared product term, enables the output drivers of the whole port.

The whole configuration is loaded one bit per clock through a serial shift chain. This configuration covers every array connection plus a mode bit and a polarity bit per cell. Until a complete load has been shifted in, every pin stays tri-stated. The pads are modelled outside the block through separate value, enable and read-back vectors, so no tri-state nets are needed. Apart from the configuration store, the datapath is purely combinational.

Top module: `sop_port_array`

## Requirements
- R1: After reset, cfg_done is 0 and pin_oe is all zero. No pin is driven until a complete configuration has been loaded.
- R2: While cfg_en is 1, each rising clock edge shifts cfg_bit into the chain. The bit sent k-th (k from 0) ends at configuration index k after exactly 2458 shifts. cfg_done reads 1 right after the 2458th shift and reads 0 before it.
- R3: A shift while cfg_done is 1 starts a new load. cfg_done drops at once and pin_oe stays zero until 2458 further shifts have completed.
- R4: Configuration layout: product term t uses indices t*74 to t*74+73. In that slice, index 2j connects the true literal of array input j and index 2j+1 connects its complement. Cell c owns terms 4c to 4c+3. Term 32 is the shared output enable. Index 2442+2c is the mode of cell c (1 output, 0 input), and index 2443+2c is its polarity (1 inverts).
- R5: Array inputs 0 to 28 are ext_in[0] to ext_in[28], and inputs 29 to 36 are pin_in[0] to pin_in[7]. Pin read-back is used whatever the cell mode.
- R6: A product term is the AND of its connected literals. A term with no connected literal is 0, and a term with both literals of one input connected is 0.
- R7: pin_out[c] is the OR of cell c's four terms, XORed with its polarity bit.
- R8: pin_oe[c] is 1 exactly when cfg_done is 1, cell c is in output mode and the shared enable term is 1.
- R9: A cell in input mode never drives its pin (pin_oe[c] is 0), while its pin_in value still reaches the array.
- R10: pin_out and pin_oe follow changes on ext_in and pin_in without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_done | output | 1 | Complete configuration present |
| ext_in | input | 29 | External signals into the AND array |
| pin_in | input | 8 | Value read back from each port pad |
| pin_out | output | 8 | Value each cell presents to its pad |
| pin_oe | output | 8 | Driver enable for each pad |

## Verification
On every cycle, the assertions check several rules. No pin is enabled without a finished load, and an input-mode cell never drives. Any enabled pin implies that the shared enable term is true. An empty product term stays low. The load counter stays in range and restarts on a new load. Other behaviour only shows up in the bench's scenarios. This covers the bit ordering of the serial chain and the mapping of fuse indices to literals, cells and the enable term. It also covers the pin read-back path, the clash of both literals and the exact shift count at which cfg_done rises. These are checked against a directed map and randomly drawn maps, evaluated by an independent sum-of-products model.

// File: rtl/sop_port_pkg.sv
package sop_port_pkg;
  localparam int unsigned DEF_EXT_W = 29;
  localparam int unsigned DEF_CELLS = 8;
  localparam int unsigned DEF_PTS   = 4;
endpackage

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int unsigned BITS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            shift_bit,
  output logic [BITS-1:0] image,
  output logic            loaded
);
  localparam int unsigned CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);

  logic [BITS-1:0]  img_q, img_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // next state: shift toward index 0, count shifts, restart after a full load
  always_comb begin
    img_d = {shift_bit, img_q[BITS-1:1]};
    if (cnt_q == FULL) cnt_d = CNT_W'(1);
    else               cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q <= '0;
      cnt_q <= '0;
    end else if (shift_en) begin
      img_q <= img_d;
      cnt_q <= cnt_d;
    end
  end

  assign image  = img_q;
  assign loaded = (cnt_q == FULL);

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  assert_hold_without_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cnt_q));
  assert_reload_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && loaded) |=> !loaded);
endmodule

// File: rtl/sop_and_array.sv
module sop_and_array #(
  parameter int unsigned IN_W  = 37,
  parameter int unsigned TERMS = 33
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TERMS*2*IN_W-1:0] fuses,
  input  logic [IN_W-1:0]         arr_in,
  output logic [TERMS-1:0]        pt
);
  localparam int unsigned TB = 2 * IN_W;

  for (genvar t = 0; t < TERMS; t++) begin : g_term
    logic [TB-1:0]   slice;
    logic [IN_W-1:0] use_true, use_comp, lit_ok;
    assign slice = fuses[t*TB +: TB];
    for (genvar j = 0; j < IN_W; j++) begin : g_lit
      assign use_true[j] = slice[2*j];
      assign use_comp[j] = slice[2*j+1];
      // a true literal needs the input high, a complement literal needs it low
      assign lit_ok[j] = (~use_true[j] | arr_in[j]) & (~use_comp[j] | ~arr_in[j]);
    end
    assign pt[t] = (|slice) & (&lit_ok);

    assert_empty_term_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (slice == '0) |-> !pt[t]);
  end
endmodule

// File: rtl/sop_port_cell.sv
module sop_port_cell #(
  parameter int unsigned PTS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PTS-1:0] terms,
  input  logic           mode_out,
  input  logic           invert,
  input  logic           oe_term,
  input  logic           cfg_ok,
  output logic           drive,
  output logic           drive_en
);
  logic sum;
  assign sum      = |terms;
  assign drive    = sum ^ invert;
  assign drive_en = cfg_ok & mode_out & oe_term;

  assert_input_mode_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_out |-> !drive_en);
  assert_idle_terms_give_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (terms == '0) |-> (drive == invert));
endmodule

// File: rtl/sop_port_array.sv
module sop_port_array
  import sop_port_pkg::*;
#(
  parameter int unsigned EXT_W = DEF_EXT_W,
  parameter int unsigned CELLS = DEF_CELLS,
  parameter int unsigned PTS   = DEF_PTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  output logic             cfg_done,
  input  logic [EXT_W-1:0] ext_in,
  input  logic [CELLS-1:0] pin_in,
  output logic [CELLS-1:0] pin_out,
  output logic [CELLS-1:0] pin_oe
);
  localparam int unsigned ARR_W      = EXT_W + CELLS;
  localparam int unsigned TERMS      = CELLS * PTS + 1;
  localparam int unsigned OE_IDX     = CELLS * PTS;
  localparam int unsigned ARRAY_BITS = TERMS * 2 * ARR_W;
  localparam int unsigned TOTAL      = ARRAY_BITS + 2 * CELLS;

  logic [TOTAL-1:0] image;
  logic [ARR_W-1:0] arr_in;
  logic [TERMS-1:0] pt;
  logic [CELLS-1:0] out_mode;

  cfg_shift_chain #(.BITS(TOTAL)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_en(cfg_en), .shift_bit(cfg_bit),
    .image(image), .loaded(cfg_done)
  );

  assign arr_in = {pin_in, ext_in};

  sop_and_array #(.IN_W(ARR_W), .TERMS(TERMS)) u_array (
    .clk(clk), .rst_n(rst_n), .fuses(image[ARRAY_BITS-1:0]),
    .arr_in(arr_in), .pt(pt)
  );

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    assign out_mode[c] = image[ARRAY_BITS + 2*c];
    sop_port_cell #(.PTS(PTS)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .terms(pt[c*PTS +: PTS]),
      .mode_out(out_mode[c]),
      .invert(image[ARRAY_BITS + 2*c + 1]),
      .oe_term(pt[OE_IDX]),
      .cfg_ok(cfg_done),
      .drive(pin_out[c]),
      .drive_en(pin_oe[c])
    );
  end

  assert_unloaded_tristate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> (pin_oe == '0));
  assert_drive_needs_shared_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != '0) |-> pt[OE_IDX]);
  assert_enabled_set_matches_modes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != '0) |-> (pin_oe == out_mode));
endmodule

// File: tb/sop_port_array_test.sv
`timescale 1ns/1ps
module sop_port_array_test;
  localparam int EXT_W = 29;
  localparam int CELLS = 8;
  localparam int PTS   = 4;
  localparam int ARR_W = EXT_W + CELLS;
  localparam int TERMS = CELLS * PTS + 1;
  localparam int TB    = 2 * ARR_W;
  localparam int ABITS = TERMS * TB;
  localparam int TOTAL = ABITS + 2 * CELLS;

  // {ext_in, pin_in, expected pin_out, expected pin_oe}
  localparam logic [52:0] VEC [6] = '{
    {29'h0000_0000, 8'h00, 8'h04, 8'h7F},
    {29'h0000_0003, 8'h80, 8'h97, 8'h7F},
    {29'h1000_0008, 8'h00, 8'h64, 8'h7F},
    {29'h1000_0034, 8'h7F, 8'h24, 8'h7F},
    {29'h0000_0041, 8'h80, 8'h96, 8'h00},
    {29'h1FFF_FFFF, 8'hFF, 8'hB7, 8'h00}
  };

  logic clk, rst_n, cfg_en, cfg_bit, cfg_done;
  logic [EXT_W-1:0] ext_in;
  logic [CELLS-1:0] pin_in, pin_out, pin_oe;
  logic [TOTAL-1:0] fm;
  int total, bad;

  sop_port_array uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_done(cfg_done), .ext_in(ext_in), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic set_lit(input int t, input int j, input int neg);
    fm[t*TB + 2*j + neg] = 1'b1;
  endtask

  task automatic set_cell(input int c, input bit mode, input bit pol);
    fm[ABITS + 2*c]     = mode;
    fm[ABITS + 2*c + 1] = pol;
  endtask

  task automatic shift_range(input int lo, input int hi);
    for (int k = lo; k <= hi; k++) begin
      cfg_en  = 1'b1;
      cfg_bit = fm[k];
      @(posedge clk);
      @(negedge clk);
    end
    cfg_en = 1'b0;
  endtask

  task automatic model(input logic [EXT_W-1:0] e, input logic [CELLS-1:0] p,
                       output logic [CELLS-1:0] o, output logic [CELLS-1:0] oe);
    logic [ARR_W-1:0] a;
    logic [TERMS-1:0] pt;
    a = {p, e};
    for (int t = 0; t < TERMS; t++) begin
      bit any, val;
      any = 0; val = 1;
      for (int j = 0; j < ARR_W; j++) begin
        if (fm[t*TB + 2*j] || fm[t*TB + 2*j + 1]) any = 1;
        if (fm[t*TB + 2*j] && !a[j]) val = 0;
        if (fm[t*TB + 2*j + 1] && a[j]) val = 0;
      end
      pt[t] = any & val;
    end
    for (int c = 0; c < CELLS; c++) begin
      o[c]  = (|pt[c*PTS +: PTS]) ^ fm[ABITS + 2*c + 1];
      oe[c] = fm[ABITS + 2*c] & pt[TERMS-1];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CELLS-1:0] eo, eoe;
    total = 0; bad = 0;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_bit = 1'b0;
    ext_in = '0; pin_in = '0;
    // directed map; polarity and mode per cell per R4
    fm = '0;
    set_lit(0, 0, 0); set_lit(0, 1, 0);            // cell0: e0 & e1
    set_lit(4, 0, 1);                              // cell1: !e0, inverted
    set_lit(12, 2, 0); set_lit(12, 2, 1);          // cell3: clashing literals
    set_lit(16, 36, 0);                            // cell4: pin_in[7] read back
    set_lit(20, 3, 0); set_lit(21, 4, 0);          // cell5: e3 | e4
    set_lit(24, 28, 0); set_lit(24, 5, 1);         // cell6: e28 & !e5
    set_lit(28, 0, 0);                             // cell7: input mode
    set_lit(32, 6, 1);                             // shared enable: !e6
    for (int c = 0; c < 7; c++) set_cell(c, 1'b1, 1'b0);
    set_cell(1, 1'b1, 1'b1);
    set_cell(2, 1'b1, 1'b1);
    set_cell(7, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", 32'(cfg_done), 32'd0);
    check("R1 oe after reset", 32'(pin_oe), 32'd0);

    shift_range(0, TOTAL/2 - 1);
    check("R2 done mid load", 32'(cfg_done), 32'd0);
    check("R1 oe mid load", 32'(pin_oe), 32'd0);
    shift_range(TOTAL/2, TOTAL - 2);
    check("R2 done one shift short", 32'(cfg_done), 32'd0);
    shift_range(TOTAL - 1, TOTAL - 1);
    check("R2 done after full load", 32'(cfg_done), 32'd1);

    // table walk; no clock edges between vectors (R10)
    foreach (VEC[i]) begin
      ext_in = VEC[i][52:24];
      pin_in = VEC[i][23:16];
      #1;
      check("R4 R5 R6 R7 table pin_out", 32'(pin_out), 32'(VEC[i][15:8]));
      check("R8 R9 table pin_oe", 32'(pin_oe), 32'(VEC[i][7:0]));
    end

    // R10: combinational response to pin read-back change only
    ext_in = '0; pin_in = 8'h00; #1;
    pin_in = 8'h80; #1;
    check("R10 pin_out follows pin_in", 32'(pin_out[4]), 32'd1);
    check("R9 input cell never drives", 32'(pin_oe[7]), 32'd0);

    // R3: reload restarts and tri-states
    @(negedge clk);
    shift_range(0, 0);
    check("R3 done dropped on reload", 32'(cfg_done), 32'd0);
    check("R3 oe during reload", 32'(pin_oe), 32'd0);
    shift_range(1, TOTAL - 1);
    check("R3 done after reload", 32'(cfg_done), 32'd1);
    ext_in = 29'h0000_0003; pin_in = 8'h80; #1;
    check("R3 map intact after reload", 32'(pin_out), 32'h97);

    // random sparse maps against the model
    for (int m = 0; m < 10; m++) begin
      fm = '0;
      for (int t = 0; t < TERMS; t++) begin
        int n;
        n = (t == TERMS - 1) ? int'($urandom_range(1, 2)) : int'($urandom_range(0, 3));
        for (int i = 0; i < n; i++)
          set_lit(t, int'($urandom_range(0, ARR_W - 1)), int'($urandom_range(0, 1)));
      end
      for (int c = 0; c < CELLS; c++)
        set_cell(c, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      @(negedge clk);
      shift_range(0, TOTAL - 1);
      check("R2 random load done", 32'(cfg_done), 32'd1);
      for (int v = 0; v < 40; v++) begin
        ext_in = EXT_W'($urandom);
        pin_in = CELLS'($urandom);
        #1;
        model(ext_in, pin_in, eo, eoe);
        check("R6 R7 random pin_out", 32'(pin_out), 32'(eo));
        check("R8 R9 random pin_oe", 32'(pin_oe), 32'(eoe));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule